// File: doc/BRIEF.md
# Rotating Register File with Base-Offset Renaming

This block is a register file for software-pipelined loops. Its index space has two halves. The lower half is a plain set of registers that are addressed directly. In the upper half, every logical specifier is shifted by a base value before it selects a physical entry, and the shifted index wraps within that half.

Each loop-closing branch pulses one strobe, and that strobe lowers the base by one. A result written under logical register n in one iteration can then be read as logical n+k after k more iterations. The compiler can therefore express an operation's latency as a distance between register numbers, and it needs no copy instructions and no duplicated prologue or epilogue code.

The file has two combinational read ports and one clocked write port. Each port takes a logical specifier and has its own translator.

Top module: `rot_regfile`

## Requirements
- R1: A logical specifier below 32 selects the fixed physical entry with the same number, whatever the base value.
- R2: A logical specifier s in 32..63 selects physical entry 32 + ((s - 32 + base) mod 32).
- R3: Each clock edge with `rotate_i` high lowers the base by one. With `rotate_i` low, the base keeps its value.
- R4: Lowering the base from 0 gives 31.
- R5: A write with `wr_en_i` high takes effect at the clock edge and uses the base that is current in that cycle. This holds even when `rotate_i` is high in the same cycle.
- R6: Both read ports are combinational and independent of each other. A read of the physical entry that is being written in the same cycle returns the value it held before that write.
- R7: An active-low reset sets the base and every register to 0.
- R8: A value written to rotating logical register n reads back as logical n+k after k rotate strobes, as long as n+k stays at or below 63.
- R9: With `wr_en_i` low, no register changes, whatever is on `wr_lidx_i` and `wr_data_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rotate_i | input | 1 | Loop-closing branch strobe, lowers the base |
| wr_en_i | input | 1 | Write enable |
| wr_lidx_i | input | 6 | Logical specifier of the write |
| wr_data_i | input | 32 | Write data |
| rd0_lidx_i | input | 6 | Logical specifier of read port 0 |
| rd0_data_o | output | 32 | Read port 0 data |
| rd1_lidx_i | input | 6 | Logical specifier of read port 1 |
| rd1_data_o | output | 32 | Read port 1 data |

## Verification
On every cycle, the assertions check three things:
- the base steps down by one, holds when there is no strobe, and wraps from 0 to 31;
- every translated rotating specifier stays inside the upper half;
- each enabled write lands at the physical entry its translator chose.

The bench scenarios cover the rest:
- the values seen at the ports, since the base is not visible outside the block;
- values flowing across iterations;
- write-before-rotate ordering in a shared cycle;
- the old value returned on a same-cycle read and write;
- suppressed writes;
- a second reset in the middle of a run.

// File: rtl/rrf_pkg.sv
package rrf_pkg;
  localparam int unsigned DEF_DATA_W = 32;
  localparam int unsigned DEF_FIXED  = 32;
  localparam int unsigned DEF_ROT    = 32;

  typedef enum logic {
    SEC_FIXED = 1'b0,
    SEC_ROT   = 1'b1
  } section_e;
endpackage

// File: rtl/rrf_base.sv
module rrf_base #(
  parameter int unsigned ROT_REGS = 32,
  parameter int unsigned ROT_W    = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             rotate_i,
  output logic [ROT_W-1:0] base_o
);
  localparam logic [ROT_W-1:0] BASE_MAX = ROT_W'(ROT_REGS - 1);

  logic [ROT_W-1:0] base_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       base_q <= '0;
    else if (rotate_i) base_q <= (base_q == '0) ? BASE_MAX : base_q - 1'b1;
  end

  assign base_o = base_q;

  a_r3_step_down: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rotate_i && base_q != '0) |=> (base_q == $past(base_q) - 1'b1));

  a_r3_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rotate_i |=> $stable(base_q));

  a_r4_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rotate_i && base_q == '0) |=> (base_q == BASE_MAX));
endmodule

// File: rtl/rrf_xlate.sv
module rrf_xlate
  import rrf_pkg::*;
#(
  parameter int unsigned FIXED_REGS = 32,
  parameter int unsigned ROT_REGS   = 32,
  parameter int unsigned IDX_W      = 6,
  parameter int unsigned ROT_W      = 5
) (
  input  logic [IDX_W-1:0] lidx_i,
  input  logic [ROT_W-1:0] base_i,
  output logic [IDX_W-1:0] pidx_o
);
  localparam logic [IDX_W-1:0] ROT_START = IDX_W'(FIXED_REGS);
  localparam logic [ROT_W:0]   ROT_SPAN  = (ROT_W+1)'(ROT_REGS);

  section_e         sec;
  logic [ROT_W-1:0] off;
  logic [ROT_W:0]   sum;
  logic [ROT_W:0]   wrapped;

  always_comb begin
    sec     = (lidx_i >= ROT_START) ? SEC_ROT : SEC_FIXED;
    off     = ROT_W'(lidx_i - ROT_START);
    sum     = {1'b0, off} + {1'b0, base_i};
    // the sum is below twice the span, so one subtraction is enough
    wrapped = (sum >= ROT_SPAN) ? sum - ROT_SPAN : sum;
    pidx_o  = (sec == SEC_ROT) ? ROT_START + IDX_W'(wrapped) : lidx_i;
  end

  always_comb begin
    if (sec == SEC_ROT) begin
      a_r2_stays_rotating: assert (pidx_o >= ROT_START);
    end
  end
endmodule

// File: rtl/rrf_storage.sv
module rrf_storage #(
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned NUM_REGS = 64,
  parameter int unsigned IDX_W    = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [IDX_W-1:0]  waddr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [IDX_W-1:0]  raddr0_i,
  input  logic [IDX_W-1:0]  raddr1_i,
  output logic [DATA_W-1:0] rdata0_o,
  output logic [DATA_W-1:0] rdata1_o
);
  logic [DATA_W-1:0] regs [NUM_REGS];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < int'(NUM_REGS); i++) regs[i] <= '0;
    end else if (we_i) begin
      regs[waddr_i] <= wdata_i;
    end
  end

  // reads see the array before the edge, so a same-cycle write is not forwarded
  assign rdata0_o = regs[raddr0_i];
  assign rdata1_o = regs[raddr1_i];

  a_r5_write_lands: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> (regs[$past(waddr_i)] == $past(wdata_i)));
endmodule

// File: rtl/rot_regfile.sv
module rot_regfile
  import rrf_pkg::*;
#(
  parameter  int unsigned DATA_W     = DEF_DATA_W,
  parameter  int unsigned FIXED_REGS = DEF_FIXED,
  parameter  int unsigned ROT_REGS   = DEF_ROT,
  localparam int unsigned NUM_REGS   = FIXED_REGS + ROT_REGS,
  localparam int unsigned IDX_W      = $clog2(NUM_REGS),
  localparam int unsigned ROT_W      = $clog2(ROT_REGS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rotate_i,
  input  logic              wr_en_i,
  input  logic [IDX_W-1:0]  wr_lidx_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic [IDX_W-1:0]  rd0_lidx_i,
  output logic [DATA_W-1:0] rd0_data_o,
  input  logic [IDX_W-1:0]  rd1_lidx_i,
  output logic [DATA_W-1:0] rd1_data_o
);
  localparam int unsigned NUM_PORTS = 3;

  logic [ROT_W-1:0] base;
  logic [NUM_PORTS-1:0][IDX_W-1:0] lidx;
  logic [NUM_PORTS-1:0][IDX_W-1:0] pidx;

  assign lidx[0] = wr_lidx_i;
  assign lidx[1] = rd0_lidx_i;
  assign lidx[2] = rd1_lidx_i;

  rrf_base #(
    .ROT_REGS (ROT_REGS),
    .ROT_W    (ROT_W)
  ) u_base (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .rotate_i (rotate_i),
    .base_o   (base)
  );

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_xlate
    rrf_xlate #(
      .FIXED_REGS (FIXED_REGS),
      .ROT_REGS   (ROT_REGS),
      .IDX_W      (IDX_W),
      .ROT_W      (ROT_W)
    ) u_xlate (
      .lidx_i (lidx[p]),
      .base_i (base),
      .pidx_o (pidx[p])
    );
  end

  rrf_storage #(
    .DATA_W   (DATA_W),
    .NUM_REGS (NUM_REGS),
    .IDX_W    (IDX_W)
  ) u_storage (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .we_i     (wr_en_i),
    .waddr_i  (pidx[0]),
    .wdata_i  (wr_data_i),
    .raddr0_i (pidx[1]),
    .raddr1_i (pidx[2]),
    .rdata0_o (rd0_data_o),
    .rdata1_o (rd1_data_o)
  );
endmodule

// File: tb/rot_regfile_bench.sv
`timescale 1ns/1ps
module rot_regfile_bench;
  localparam int DW  = 32;
  localparam int FIX = 32;
  localparam int ROT = 32;
  localparam int NR  = 64;
  localparam int IW  = 6;

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic          rotate_i = 1'b0;
  logic          wr_en_i = 1'b0;
  logic [IW-1:0] wr_lidx_i = '0;
  logic [DW-1:0] wr_data_i = '0;
  logic [IW-1:0] rd0_lidx_i = '0;
  logic [IW-1:0] rd1_lidx_i = '0;
  logic [DW-1:0] rd0_data_o, rd1_data_o;

  always #2.5 clk = ~clk;

  rot_regfile u_rot_regfile (
    .clk_i      (clk),
    .rst_ni     (rst_ni),
    .rotate_i   (rotate_i),
    .wr_en_i    (wr_en_i),
    .wr_lidx_i  (wr_lidx_i),
    .wr_data_i  (wr_data_i),
    .rd0_lidx_i (rd0_lidx_i),
    .rd0_data_o (rd0_data_o),
    .rd1_lidx_i (rd1_lidx_i),
    .rd1_data_o (rd1_data_o)
  );

  typedef struct {
    string         tag;
    logic [DW-1:0] e0;
    logic [DW-1:0] e1;
  } exp_t;

  exp_t          exp_q[$];
  logic [DW-1:0] ref_mem [NR];
  int            ref_base = 0;
  int            n_vec = 0;
  int            n_bad = 0;
  event          sample_ev;

  // mapping taken from R1 and R2
  function automatic int map_idx(int l, int b);
    if (l < FIX) return l;
    return FIX + ((l - FIX + b) % ROT);
  endfunction

  task automatic clear_ref();
    for (int i = 0; i < NR; i++) ref_mem[i] = '0;
    ref_base = 0;
  endtask

  task automatic step(bit rot, bit we, int wl, logic [DW-1:0] wd, int r0, int r1, string tag);
    exp_t e;
    @(negedge clk);
    rotate_i   = rot;
    wr_en_i    = we;
    wr_lidx_i  = IW'(wl);
    wr_data_i  = wd;
    rd0_lidx_i = IW'(r0);
    rd1_lidx_i = IW'(r1);
    e.tag = tag;
    e.e0  = ref_mem[map_idx(r0, ref_base)];
    e.e1  = ref_mem[map_idx(r1, ref_base)];
    exp_q.push_back(e);
    #1 -> sample_ev;
    // the write uses the old base (R5); rotation follows R3 and R4
    if (we) ref_mem[map_idx(wl, ref_base)] = wd;
    if (rot) ref_base = (ref_base == 0) ? ROT - 1 : ref_base - 1;
  endtask

  task automatic rd(int r0, int r1, string tag);
    step(1'b0, 1'b0, 0, '0, r0, r1, tag);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_ni   = 1'b0;
    rotate_i = 1'b0;
    wr_en_i  = 1'b0;
    #7;
    clear_ref();
    @(negedge clk);
    rst_ni = 1'b1;
  endtask

  always @(sample_ev) begin
    exp_t e;
    e = exp_q.pop_front();
    n_vec++;
    if (rd0_data_o !== e.e0) begin
      n_bad++;
      $display("FAIL %s port0: actual=%h expected=%h", e.tag, rd0_data_o, e.e0);
    end
    if (rd1_data_o !== e.e1) begin
      n_bad++;
      $display("FAIL %s port1: actual=%h expected=%h", e.tag, rd1_data_o, e.e1);
    end
  end

  initial begin
    #(200000 * 5.0);
    n_bad++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    clear_ref();
    #12;
    rst_ni = 1'b1;

    // R7: everything starts at zero
    rd(0, 63, "R7 reset");
    rd(31, 32, "R7 reset");

    // R1: a fixed register is not moved by rotation
    step(1'b0, 1'b1, 5, 32'hF1F0_0005, 5, 6, "R6 same-cycle old value");
    rd(5, 6, "R1 fixed read");
    step(1'b1, 1'b0, 0, '0, 5, 5, "R1 fixed");
    step(1'b1, 1'b0, 0, '0, 5, 31, "R1 fixed");
    rd(5, 5, "R1 fixed after rotate");

    // R8: a value moves up one logical number per rotation
    step(1'b0, 1'b1, 40, 32'hA5A5_0040, 40, 40, "R6 same-cycle old value");
    rd(40, 41, "R2 rotating read");
    for (int k = 0; k < 3; k++) step(1'b1, 1'b0, 0, '0, 40 + k, 41 + k, "R3 rotate");
    rd(43, 40, "R8 value at n+3");

    // R4: wrap from base 0; physical 63 is reached again by logical 32
    do_reset();
    step(1'b0, 1'b1, 63, 32'h6363_6363, 63, 32, "R2 top entry write");
    step(1'b1, 1'b0, 0, '0, 63, 32, "R4 rotate at zero");
    rd(32, 63, "R4 wrapped base reads 63 via 32");

    // R5: a write and a rotation in the same cycle use the old base
    step(1'b1, 1'b1, 50, 32'h5050_5050, 50, 51, "R5 write+rotate");
    rd(51, 50, "R5 old-base write seen at n+1");

    // R9: a write with the enable low changes nothing
    step(1'b0, 1'b0, 51, 32'hDEAD_BEEF, 51, 5, "R9 disabled write");
    rd(51, 5, "R9 no change");

    // R2, R6: sweep every logical register, then rotate and read them all
    for (int l = 0; l < NR; l++)
      step(1'b0, 1'b1, l, 32'h1000_0000 + l * 7, l, (l + 1) % NR, "R2 sweep write");
    for (int k = 0; k < 5; k++) step(1'b1, 1'b0, 0, '0, k, 32 + k, "R3 rotate");
    for (int l = 0; l < NR; l += 2) rd(l, l + 1, "R2 sweep read");

    // R8 and R4 over many iterations, with writes and rotations in the same cycle
    for (int i = 0; i < 70; i++)
      step(1'b1, 1'b1, 32 + (i % 32), 32'hC000_0000 + i, 32 + ((i + 1) % 32), 32 + (i % 32),
           "R8 pipelined flow");
    for (int l = 32; l < NR; l += 2) rd(l, l + 1, "R8 pipelined read");

    // R7: a second reset clears the file and the base
    do_reset();
    for (int l = 0; l < NR; l += 2) rd(l, l + 1, "R7 reset again");
    step(1'b0, 1'b1, 33, 32'h0000_0033, 33, 1, "R6 same-cycle old value");
    rd(33, 1, "R7 base back at zero");

    @(negedge clk);
    #2;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule